// File: doc/BRIEF.md
# Serial-Programmed Synthesizer Control Register File

This block is the write-only control port of a chip with several frequency synthesizers. A host sends 22-bit words over a three-wire serial link: a bit clock, a data line and an active-low frame enable. The block rebuilds each word in the system clock domain and commits it when the enable rises. Every word carries 18 data bits first and a 4-bit register address last. Because the address comes last, the block can only decode a write once the frame has closed.

The committed word updates one of nine configuration registers. These are a main configuration word, the phase-detector gain codes, the power-control bits, and the feedback (N) and reference (R) divider values for the RF1, RF2 and IF loops. All values leave the block as plain register outputs. The block also forms the power enables for the IF, RF and reference sections by combining a hardware powerdown pin with two register bits. It tracks which RF oscillator drives the shared RF output, and that selection follows the RF N register written most recently.

The serial receiver is a three-state machine:
- RX_IDLE waits for the enable to fall.
- RX_SHIFT shifts one bit on every bit-clock rise.
- RX_COMMIT issues a single write pulse.

The transitions are:
- idle-to-shift on an enable fall.
- shift-to-commit on an enable rise after exactly 22 bits.
- shift-to-idle on an enable rise after any other bit count.
- commit-to-idle unconditionally.

Top module: `synth_cfg_regfile`

## Requirements
- R1: Data is sampled on each rising bit clock while the enable is low, first bit first. The first bit is D17, data bits D17..D0 follow, and the last four bits are the address A3..A0. The write is committed after the enable rises.
- R2: A frame with any bit count other than 22 changes no register.
- R3: A 22-bit frame addressed to 9 through 15 changes no register.
- R4: Address map: 0 main, 1 gain, 2 power, 3 RF1 N, 4 RF2 N, 5 IF N, 6 RF1 R, 7 RF2 R, 8 IF R.
- R5: The main register fields are mapped as follows. Other data bits are ignored.
  - aux_sel = D13:12
  - if_div = D11:10
  - xin_half = D6
  - low_pwr = D5
  - auto_pd = D3
- R6: The gain register fields are kp_if = D1:0, kp_rf2 = D3:2 and kp_rf1 = D5:4.
- R7: N registers keep the low N_W data bits. R registers keep the low R_W data bits, and higher data bits are ignored.
- R8: While pwdn_pin is low, if_en, rf_en and ref_en are all 0.
- R9: While pwdn_pin is high, if_en equals power bit D1 and rf_en equals power bit D0. ref_en is high if either of them is high.
- R10: A write to address 3 sets rf_sel to 0 (RF1), and a write to address 4 sets it to 1 (RF2). No other write changes rf_sel.
- R11: After reset every register is zero, all enables are off and rf_sel is 0.
- R12: Bit-clock edges while the enable is high change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial bit clock |
| sdata | input | 1 | Serial data |
| sen | input | 1 | Frame enable, active low |
| pwdn_pin | input | 1 | Hardware powerdown pin, low forces all sections off |
| aux_sel | output | 2 | Auxiliary output select |
| if_div | output | 2 | IF output divider code |
| xin_half | output | 1 | Reference input divide-by-2 enable |
| low_pwr | output | 1 | Low-power mode |
| auto_pd | output | 1 | Automatic powerdown enable |
| kp_if | output | 2 | IF phase-detector gain code |
| kp_rf2 | output | 2 | RF2 phase-detector gain code |
| kp_rf1 | output | 2 | RF1 phase-detector gain code |
| rf1_n | output | N_W | RF1 N divider |
| rf2_n | output | N_W | RF2 N divider |
| if_n | output | N_W | IF N divider |
| rf1_r | output | R_W | RF1 R divider |
| rf2_r | output | R_W | RF2 R divider |
| if_r | output | R_W | IF R divider |
| if_en | output | 1 | IF section enable |
| rf_en | output | 1 | RF section enable |
| ref_en | output | 1 | Reference amplifier enable |
| rf_sel | output | 1 | Active RF oscillator, 0 RF1, 1 RF2 |

## Verification
The assertions watch the following on every cycle:
- The power gating by the pin and the agreement between the reference enable and the two section enables.
- That each commit is a single-cycle pulse.
- That rf_sel only moves after a write to an RF N address.
- That writes to a reserved address leave every register unchanged.

Only the bench's scenarios can show the rest, because each of these depends on a whole serial frame:
- The bit order across the frame.
- The rejection of short and long frames.
- The field placement in each register.
- That bit-clock activity outside a frame has no effect.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
    localparam int WORD_W = 22;
    localparam int ADDR_W = 4;
    localparam int DATA_W = WORD_W - ADDR_W;

    localparam logic [ADDR_W-1:0] AD_MAIN  = 4'd0;
    localparam logic [ADDR_W-1:0] AD_GAIN  = 4'd1;
    localparam logic [ADDR_W-1:0] AD_PWR   = 4'd2;
    localparam logic [ADDR_W-1:0] AD_N_BASE = 4'd3;
    localparam logic [ADDR_W-1:0] AD_R_BASE = 4'd6;
    localparam logic [ADDR_W-1:0] AD_LAST  = 4'd8;
    localparam int NUM_LOOPS = 3;  // index 0 RF1, 1 RF2, 2 IF

    typedef enum logic [1:0] {
        RX_IDLE   = 2'd0,
        RX_SHIFT  = 2'd1,
        RX_COMMIT = 2'd2
    } rx_state_t;

    typedef enum logic {
        SEL_RF1 = 1'b0,
        SEL_RF2 = 1'b1
    } rf_sel_t;

    typedef struct packed {
        logic [1:0] aux_sel;
        logic [1:0] if_div;
        logic       xin_half;
        logic       low_pwr;
        logic       auto_pd;
    } main_cfg_t;

    typedef struct packed {
        logic [1:0] kp_rf1;
        logic [1:0] kp_rf2;
        logic [1:0] kp_if;
    } gain_cfg_t;
endpackage

// File: rtl/synth_serial_rx.sv
module synth_serial_rx
    import synth_cfg_pkg::*;
#(
    parameter int FRAME_W = WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               sdata,
    input  logic               sen,
    output logic               word_valid,
    output logic [FRAME_W-1:0] word
);
    localparam int CNT_W = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

    logic [2:0] sclk_q;
    logic [2:0] sen_q;
    logic [1:0] sdata_q;
    logic       sclk_rise;
    logic       sen_fall;
    logic       sen_rise;

    rx_state_t          state, state_nx;
    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] shreg;

    // Three-stage samplers; the oldest two stages give the edges.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q  <= '0;
            sen_q   <= '1;
            sdata_q <= '0;
        end else begin
            sclk_q  <= {sclk_q[1:0], sclk};
            sen_q   <= {sen_q[1:0], sen};
            sdata_q <= {sdata_q[0], sdata};
        end
    end

    assign sclk_rise = sclk_q[1] & ~sclk_q[2];
    assign sen_fall  = ~sen_q[1] & sen_q[2];
    assign sen_rise  = sen_q[1] & ~sen_q[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE:   if (sen_fall) state_nx = RX_SHIFT;
            RX_SHIFT:  if (sen_rise) state_nx = (bit_cnt == CNT_FULL) ? RX_COMMIT : RX_IDLE;
            RX_COMMIT: state_nx = RX_IDLE;
            default:   state_nx = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (state == RX_IDLE && sen_fall) begin
            bit_cnt <= '0;
        end else if (state == RX_SHIFT && sclk_rise && !sen_rise) begin
            shreg <= {shreg[FRAME_W-2:0], sdata_q[1]};
            if (bit_cnt != CNT_OVER) bit_cnt <= bit_cnt + 1'b1;
        end
    end

    always_comb begin
        word_valid = (state == RX_COMMIT);
        word       = shreg;
    end
endmodule

// File: rtl/synth_cfg_bank.sv
module synth_cfg_bank
    import synth_cfg_pkg::*;
#(
    parameter int N_W = 18,
    parameter int R_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output main_cfg_t         main_cfg,
    output gain_cfg_t         gain_cfg,
    output logic              pd_if,
    output logic              pd_rf,
    output logic [N_W-1:0]    n_val [NUM_LOOPS],
    output logic [R_W-1:0]    r_val [NUM_LOOPS],
    output rf_sel_t           rf_sel
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            main_cfg <= '0;
            gain_cfg <= '0;
            pd_if    <= 1'b0;
            pd_rf    <= 1'b0;
            rf_sel   <= SEL_RF1;
        end else if (wr_en) begin
            if (wr_addr == AD_MAIN) begin
                main_cfg.aux_sel  <= wr_data[13:12];
                main_cfg.if_div   <= wr_data[11:10];
                main_cfg.xin_half <= wr_data[6];
                main_cfg.low_pwr  <= wr_data[5];
                main_cfg.auto_pd  <= wr_data[3];
            end
            if (wr_addr == AD_GAIN) begin
                gain_cfg.kp_if  <= wr_data[1:0];
                gain_cfg.kp_rf2 <= wr_data[3:2];
                gain_cfg.kp_rf1 <= wr_data[5:4];
            end
            if (wr_addr == AD_PWR) begin
                pd_if <= wr_data[1];
                pd_rf <= wr_data[0];
            end
            if (wr_addr == AD_N_BASE)        rf_sel <= SEL_RF1;
            if (wr_addr == AD_N_BASE + 4'd1) rf_sel <= SEL_RF2;
        end
    end

    for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                n_val[g] <= '0;
                r_val[g] <= '0;
            end else if (wr_en) begin
                if (wr_addr == AD_N_BASE + ADDR_W'(g)) n_val[g] <= wr_data[N_W-1:0];
                if (wr_addr == AD_R_BASE + ADDR_W'(g)) r_val[g] <= wr_data[R_W-1:0];
            end
        end
    end
endmodule

// File: rtl/synth_pwr_ctl.sv
module synth_pwr_ctl (
    input  logic pwdn_pin,
    input  logic pd_if,
    input  logic pd_rf,
    output logic if_en,
    output logic rf_en,
    output logic ref_en
);
    always_comb begin
        if_en  = pwdn_pin & pd_if;
        rf_en  = pwdn_pin & pd_rf;
        ref_en = pwdn_pin & (pd_if | pd_rf);
    end
endmodule

// File: rtl/synth_cfg_regfile.sv
module synth_cfg_regfile
    import synth_cfg_pkg::*;
#(
    parameter int N_W = 18,
    parameter int R_W = 13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sclk,
    input  logic           sdata,
    input  logic           sen,
    input  logic           pwdn_pin,
    output logic [1:0]     aux_sel,
    output logic [1:0]     if_div,
    output logic           xin_half,
    output logic           low_pwr,
    output logic           auto_pd,
    output logic [1:0]     kp_if,
    output logic [1:0]     kp_rf2,
    output logic [1:0]     kp_rf1,
    output logic [N_W-1:0] rf1_n,
    output logic [N_W-1:0] rf2_n,
    output logic [N_W-1:0] if_n,
    output logic [R_W-1:0] rf1_r,
    output logic [R_W-1:0] rf2_r,
    output logic [R_W-1:0] if_r,
    output logic           if_en,
    output logic           rf_en,
    output logic           ref_en,
    output logic           rf_sel
);
    logic              rx_valid;
    logic [WORD_W-1:0] rx_word;
    main_cfg_t         main_cfg;
    gain_cfg_t         gain_cfg;
    logic              pd_if, pd_rf;
    logic [N_W-1:0]    n_val [NUM_LOOPS];
    logic [R_W-1:0]    r_val [NUM_LOOPS];
    rf_sel_t           sel_q;

    synth_serial_rx #(.FRAME_W(WORD_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .sen(sen),
        .word_valid(rx_valid), .word(rx_word)
    );

    synth_cfg_bank #(.N_W(N_W), .R_W(R_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(rx_valid),
        .wr_addr(rx_word[ADDR_W-1:0]), .wr_data(rx_word[WORD_W-1:ADDR_W]),
        .main_cfg(main_cfg), .gain_cfg(gain_cfg), .pd_if(pd_if), .pd_rf(pd_rf),
        .n_val(n_val), .r_val(r_val), .rf_sel(sel_q)
    );

    synth_pwr_ctl u_pwr (
        .pwdn_pin(pwdn_pin), .pd_if(pd_if), .pd_rf(pd_rf),
        .if_en(if_en), .rf_en(rf_en), .ref_en(ref_en)
    );

    assign aux_sel  = main_cfg.aux_sel;
    assign if_div   = main_cfg.if_div;
    assign xin_half = main_cfg.xin_half;
    assign low_pwr  = main_cfg.low_pwr;
    assign auto_pd  = main_cfg.auto_pd;
    assign kp_if    = gain_cfg.kp_if;
    assign kp_rf2   = gain_cfg.kp_rf2;
    assign kp_rf1   = gain_cfg.kp_rf1;
    assign rf1_n    = n_val[0];
    assign rf2_n    = n_val[1];
    assign if_n     = n_val[2];
    assign rf1_r    = r_val[0];
    assign rf2_r    = r_val[1];
    assign if_r     = r_val[2];
    assign rf_sel   = sel_q;
endmodule

// File: rtl/synth_cfg_regfile_chk.sv
module synth_cfg_regfile_chk #(
    parameter int N_W = 18,
    parameter int R_W = 13
) (
    input logic           clk,
    input logic           rst_n,
    input logic           pwdn_pin,
    input logic           if_en,
    input logic           rf_en,
    input logic           ref_en,
    input logic           rf_sel,
    input logic           wr_en,
    input logic [21:0]    wr_word,
    input logic [1:0]     aux_sel,
    input logic [1:0]     if_div,
    input logic           xin_half,
    input logic           low_pwr,
    input logic           auto_pd,
    input logic [1:0]     kp_if,
    input logic [1:0]     kp_rf2,
    input logic [1:0]     kp_rf1,
    input logic [N_W-1:0] rf1_n,
    input logic [N_W-1:0] rf2_n,
    input logic [N_W-1:0] if_n,
    input logic [R_W-1:0] rf1_r,
    input logic [R_W-1:0] rf2_r,
    input logic [R_W-1:0] if_r
);
    logic [3:0] wa;
    assign wa = wr_word[3:0];

    a_r8_pin_low_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pwdn_pin |-> (!if_en && !rf_en && !ref_en));

    a_r9_ref_tracks_sections: assert property (@(posedge clk) disable iff (!rst_n)
        ref_en == (if_en || rf_en));

    a_r1_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    a_r10_sel_only_on_n_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rf_sel) |-> ($past(wr_en) && ($past(wa) == 4'd3 || $past(wa) == 4'd4)));

    a_r10_rf1_write_selects: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wa == 4'd3) |=> (rf_sel == 1'b0));

    a_r3_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wa >= 4'd9) |=> $stable({aux_sel, if_div, xin_half, low_pwr, auto_pd,
            kp_if, kp_rf2, kp_rf1, rf1_n, rf2_n, if_n, rf1_r, rf2_r, if_r, rf_sel}));
endmodule

bind synth_cfg_regfile synth_cfg_regfile_chk #(.N_W(N_W), .R_W(R_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pwdn_pin(pwdn_pin), .if_en(if_en), .rf_en(rf_en),
    .ref_en(ref_en), .rf_sel(rf_sel), .wr_en(rx_valid), .wr_word(rx_word),
    .aux_sel(aux_sel), .if_div(if_div), .xin_half(xin_half), .low_pwr(low_pwr),
    .auto_pd(auto_pd), .kp_if(kp_if), .kp_rf2(kp_rf2), .kp_rf1(kp_rf1),
    .rf1_n(rf1_n), .rf2_n(rf2_n), .if_n(if_n), .rf1_r(rf1_r), .rf2_r(rf2_r), .if_r(if_r)
);

// File: tb/synth_cfg_regfile_tb.sv
module synth_cfg_regfile_tb;
    localparam int N_W = 18;
    localparam int R_W = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdata = 1'b0, sen = 1'b1, pwdn_pin = 1'b0;
    logic [1:0] aux_sel, if_div, kp_if, kp_rf2, kp_rf1;
    logic xin_half, low_pwr, auto_pd, if_en, rf_en, ref_en, rf_sel;
    logic [N_W-1:0] rf1_n, rf2_n, if_n;
    logic [R_W-1:0] rf1_r, rf2_r, if_r;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // expected model state
    logic [17:0] m_main, m_gain, m_pwr;
    logic [17:0] m_n [3];
    logic [17:0] m_r [3];
    logic        m_sel;

    always #10 clk = ~clk;

    synth_cfg_regfile #(.N_W(N_W), .R_W(R_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .sen(sen),
        .pwdn_pin(pwdn_pin), .aux_sel(aux_sel), .if_div(if_div), .xin_half(xin_half),
        .low_pwr(low_pwr), .auto_pd(auto_pd), .kp_if(kp_if), .kp_rf2(kp_rf2),
        .kp_rf1(kp_rf1), .rf1_n(rf1_n), .rf2_n(rf2_n), .if_n(if_n), .rf1_r(rf1_r),
        .rf2_r(rf2_r), .if_r(if_r), .if_en(if_en), .rf_en(rf_en), .ref_en(ref_en),
        .rf_sel(rf_sel)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic waitn(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // R1 framing: D17 first, A0 last; commit after enable rises
    task automatic send(input logic [3:0] addr, input logic [17:0] data, input int nbits);
        logic [21:0] w;
        w = {data, addr};
        @(negedge clk); sen = 1'b0;
        waitn(4);
        for (int i = 0; i < nbits; i++) begin
            sdata = (i < 22) ? w[21-i] : 1'b0;
            waitn(3); sclk = 1'b1;
            waitn(4); sclk = 1'b0;
            waitn(2);
        end
        waitn(3); sen = 1'b1;
        waitn(10);
        if (nbits == 22) begin
            case (addr)
                4'd0: m_main = data;
                4'd1: m_gain = data;
                4'd2: m_pwr  = data;
                4'd3: begin m_n[0] = data; m_sel = 1'b0; end
                4'd4: begin m_n[1] = data; m_sel = 1'b1; end
                4'd5: m_n[2] = data;
                4'd6: m_r[0] = data;
                4'd7: m_r[1] = data;
                4'd8: m_r[2] = data;
                default: ;
            endcase
        end
    endtask

    function automatic logic [31:0] exp_en(input int which);
        logic i_b, r_b;
        i_b = pwdn_pin & m_pwr[1];
        r_b = pwdn_pin & m_pwr[0];
        case (which)
            0: return 32'(i_b);
            1: return 32'(r_b);
            default: return 32'(i_b | r_b);
        endcase
    endfunction

    task automatic check_all(input string tag);
        chk({tag, " R5 aux_sel"},  32'(aux_sel),  32'(m_main[13:12]));
        chk({tag, " R5 if_div"},   32'(if_div),   32'(m_main[11:10]));
        chk({tag, " R5 xin_half"}, 32'(xin_half), 32'(m_main[6]));
        chk({tag, " R5 low_pwr"},  32'(low_pwr),  32'(m_main[5]));
        chk({tag, " R5 auto_pd"},  32'(auto_pd),  32'(m_main[3]));
        chk({tag, " R6 gain"}, 32'({kp_rf1, kp_rf2, kp_if}), 32'(m_gain[5:0]));
        chk({tag, " R4 R7 rf1_n"}, 32'(rf1_n), 32'(m_n[0][N_W-1:0]));
        chk({tag, " R4 R7 rf2_n"}, 32'(rf2_n), 32'(m_n[1][N_W-1:0]));
        chk({tag, " R4 R7 if_n"},  32'(if_n),  32'(m_n[2][N_W-1:0]));
        chk({tag, " R4 R7 rf1_r"}, 32'(rf1_r), 32'(m_r[0][R_W-1:0]));
        chk({tag, " R4 R7 rf2_r"}, 32'(rf2_r), 32'(m_r[1][R_W-1:0]));
        chk({tag, " R4 R7 if_r"},  32'(if_r),  32'(m_r[2][R_W-1:0]));
        chk({tag, " R8 R9 if_en"},  32'(if_en),  exp_en(0));
        chk({tag, " R8 R9 rf_en"},  32'(rf_en),  exp_en(1));
        chk({tag, " R8 R9 ref_en"}, 32'(ref_en), exp_en(2));
        chk({tag, " R10 rf_sel"},   32'(rf_sel), 32'(m_sel));
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        m_main = '0; m_gain = '0; m_pwr = '0; m_sel = 1'b0;
        for (int k = 0; k < 3; k++) begin m_n[k] = '0; m_r[k] = '0; end
        void'($urandom(32'd4136));
        waitn(3);
        pwdn_pin = 1'b1;
        rst_n = 1'b1;
        waitn(2);
        check_all("R11 reset");

        // R9 / R8 power gating
        send(4'd2, 18'h00003, 22); check_all("R9 both on");
        pwdn_pin = 1'b0; waitn(1); check_all("R8 pin low");
        pwdn_pin = 1'b1;
        send(4'd2, 18'h00002, 22); check_all("R9 if only");

        // R10 rf select
        send(4'd4, 18'h01234, 22); check_all("R10 rf2 write");
        send(4'd5, 18'h00777, 22); check_all("R10 if n keeps sel");
        send(4'd3, 18'h3FFFF, 22); check_all("R10 rf1 write");

        // R5 / R6 field placement, reserved bits ignored
        send(4'd0, 18'h3FFFF, 22); check_all("R5 main all ones");
        send(4'd0, 18'h00048, 22); check_all("R5 main sparse");
        send(4'd1, 18'h3FFE4, 22); check_all("R6 gain");

        // R7 R width truncation
        send(4'd6, 18'h3FFFF, 22); check_all("R7 rf1 r");

        // R2 wrong lengths
        send(4'd2, 18'h00000, 21); check_all("R2 short frame");
        send(4'd0, 18'h00000, 23); check_all("R2 long frame");

        // R3 reserved addresses
        send(4'd12, 18'h3FFFF, 22); check_all("R3 addr 12");
        send(4'd9,  18'h00000, 22); check_all("R3 addr 9");
        send(4'd15, 18'h00000, 22); check_all("R3 addr 15");

        // R12 bit clock while enable high
        for (int i = 0; i < 30; i++) begin
            sdata = i[0]; waitn(2); sclk = 1'b1; waitn(2); sclk = 1'b0;
        end
        waitn(8); check_all("R12 idle clocks");

        // constrained random frames
        for (int f = 0; f < 150; f++) begin
            int  len;
            logic [3:0] a;
            logic [17:0] d;
            len = (($urandom % 8) == 0) ? (20 + ($urandom % 5)) : 22;
            a   = 4'($urandom % 16);
            d   = 18'($urandom);
            pwdn_pin = 1'($urandom);
            send(a, d, len);
            check_all("R1 random");
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule